// File: doc/BRIEF.md
# Parallel Concatenated Convolutional Encoder

This block turns one block of K information bits into a rate-1/3 coded bit stream. It has two identical recursive systematic convolutional encoders with eight states each. The first one codes the bits in arrival order. The second one codes a permuted copy of the same bits. The permutation is a quadratic polynomial address map, and its two coefficients are supplied by the user with each block. When the last information bit has been coded, both encoders are driven back to the all-zero state. The block emits the twelve bits produced by that termination after the data part.

The block works in three phases. In the first phase the source streams the K information bits in, one per accepted beat. The first beat carries a start flag, and the block size and coefficients are sampled with that beat. The bits are stored in an internal bit buffer. Once the final bit is stored, the block sends out 3K data bits and then 12 tail bits, one bit per clock cycle. The last tail bit carries an end-of-block flag. The input stays closed from the last stored bit until the stream is finished.

Top module: `pccc_encoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `out_last` are 0. After reset, `in_ready` is 1.
- R2: A block begins with an accepted beat (`in_valid` and `in_ready` both 1) that has `in_start` set. That beat samples `blk_len` (K), `coef_f1` and `coef_f2`, and its `in_bit` is information bit 0. The next K-1 accepted beats carry bits 1..K-1 in order. `in_ready` stays 1 through the whole load, and idle cycles between beats are allowed.
- R3: Each block produces exactly 3K+12 cycles with `out_valid` high, in one unbroken run. `out_last` is 1 only on the final one of these cycles.
- R4: Data output position 3k carries the systematic bit x(k). Position 3k+1 carries the first encoder's parity p1(k). Position 3k+2 carries the second encoder's parity p2(k).
- R5: Each constituent encoder holds a three-bit register (s1 newest, s3 oldest), cleared when a block starts. For input u, the feedback is a = u^s2^s3 and the parity is a^s1^s3. The register then becomes (a, s1, s2).
- R6: The second encoder's input at step k is x(pi(k)), where pi(k) = (f1·k + f2·k²) mod K. This requires f1 < K and f2 < K.
- R7: The 12 tail bits come in this order. First, the three systematic tail bits of the first encoder. Second, the three systematic tail bits of the second encoder. Third, the first encoder's three tail parities. Last, the second encoder's three tail parities. In each tail step, the encoder input equals s2^s3, which makes the feedback zero.
- R8: Once the tail bits have been produced, both encoder registers hold zero.
- R9: `in_ready` is 0 from the cycle after the final information bit is accepted until `out_valid` has fallen. Any input activity in that window has no effect on the stream of the current block or of the next block.
- R10: In the cycle after `out_last`, `out_valid` is 0.
- R11: K may be any value from 1 to MAX_K, both ends included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input beat is present |
| in_start | input | 1 | Marks the first bit of a block |
| in_bit | input | 1 | Information bit |
| blk_len | input | KW | Block size K, sampled with the start beat |
| coef_f1 | input | KW | Linear permutation coefficient, less than K |
| coef_f2 | input | KW | Quadratic permutation coefficient, less than K |
| in_ready | output | 1 | The block accepts an input beat |
| out_valid | output | 1 | `out_bit` holds a coded bit |
| out_bit | output | 1 | Coded output bit |
| out_last | output | 1 | Final tail bit of the block |

KW = ceil(log2(MAX_K+1)).

## Verification
The bench builds the encoder with MAX_K = 256, so KW = 9. With that size a full-length block takes about a thousand cycles. This makes both ends of the size range reachable in one run: the single-bit block and the block that fills the buffer completely. Block sizes, coefficients and data in between are drawn at random. The permutation reference is computed with the closed-form polynomial, and the hardware uses an incremental recurrence instead. A mismatch in the modular wrap handling therefore appears as soon as f2·k² grows past K several times.

// File: rtl/pccc_pkg.sv
// Package for the parallel concatenated encoder: shared state encoding,
// the constituent register type and the fixed output framing counts.
package pccc_pkg;

    // Control phases of the top-level sequencer
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DATA,
        ST_TAIL
    } enc_state_e;

    // Three-bit constituent register, bit 2 newest, bit 0 oldest
    typedef logic [2:0] rsc_reg_t;

    localparam int BITS_PER_STEP = 3;
    localparam int TAIL_BITS     = 12;
    localparam int TAIL_STEPS    = 3;

endpackage

// File: rtl/pccc_rsc.sv
// One recursive systematic constituent encoder with eight states.
// Feedback taps are D2 and D3, and feed-forward taps are 1, D and D3.
// Assumes: clr and step are never high in the same cycle. In term mode the
// input is replaced by the feedback sum, so a zero enters the register.
module pccc_rsc
    import pccc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr,
    input  logic     step,
    input  logic     term,
    input  logic     u,
    output logic     parity,
    output logic     sys_bit,
    output rsc_reg_t st_o
);

    rsc_reg_t st_q;
    logic     fb;

    // Pick the effective input, then form the feedback and parity bits
    always_comb begin
        sys_bit = term ? (st_q[1] ^ st_q[0]) : u;
        fb      = sys_bit ^ st_q[1] ^ st_q[0];
        parity  = fb ^ st_q[2] ^ st_q[0];
    end

    // Shift register: clear it at block start, shift it on every coding step
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st_q <= '0;
        end else if (step) begin
            st_q <= {fb, st_q[2], st_q[1]};
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/pccc_qpp.sv
// Address generator for the quadratic permutation pi(i) = (f1*i + f2*i^2) mod K.
// It uses only modular additions: the step term g(i) = f1 + f2*(2i+1) grows
// by 2*f2 on each advance. Assumes: f1 < K and f2 < K when init is high.
module pccc_qpp #(
    parameter int KW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          adv,
    input  logic [KW-1:0] k_in,
    input  logic [KW-1:0] f1_in,
    input  logic [KW-1:0] f2_in,
    output logic [KW-1:0] addr
);

    logic [KW-1:0] mod_q;
    logic [KW-1:0] pos_q;
    logic [KW-1:0] step_q;
    logic [KW-1:0] inc_q;

    // (a + b) mod m, valid when a < m and b < m
    function automatic logic [KW-1:0] mod_add(input logic [KW-1:0] a,
                                              input logic [KW-1:0] b,
                                              input logic [KW-1:0] m);
        logic [KW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) begin
            s = s - {1'b0, m};
        end
        return s[KW-1:0];
    endfunction

    // Sample the modulus and coefficients at init, then walk the permutation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q  <= '0;
            pos_q  <= '0;
            step_q <= '0;
            inc_q  <= '0;
        end else if (init) begin
            mod_q  <= k_in;
            pos_q  <= '0;
            step_q <= mod_add(f1_in, f2_in, k_in);
            inc_q  <= mod_add(f2_in, f2_in, k_in);
        end else if (adv) begin
            pos_q  <= mod_add(pos_q, step_q, mod_q);
            step_q <= mod_add(step_q, inc_q, mod_q);
        end
    end

    assign addr = pos_q;

endmodule

// File: rtl/pccc_bitbuf.sv
// Single-bit storage for one information block. It has one write port and
// two asynchronous read ports: one for natural order, one for permuted order.
// Assumes: read addresses stay below DEPTH. The contents need no reset.
module pccc_bitbuf #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wbit,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic          rbit_a,
    output logic          rbit_b
);

    logic [DEPTH-1:0] mem_q;

    // Store the incoming bit
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wbit;
        end
    end

    // Read both ports combinationally
    always_comb begin
        rbit_a = mem_q[raddr_a];
        rbit_b = mem_q[raddr_b];
    end

endmodule

// File: rtl/pccc_encoder.sv
// Top level of the parallel concatenated encoder. It loads K bits, sends
// out K triplets of (systematic, parity 1, parity 2), then sends 12 tail bits
// that bring both constituent encoders back to zero.
// Assumes: 1 <= blk_len <= MAX_K, and coef_f1, coef_f2 < blk_len at start.
module pccc_encoder
    import pccc_pkg::*;
#(
    parameter int MAX_K = 2048,
    parameter int KW    = $clog2(MAX_K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic          in_bit,
    input  logic [KW-1:0] blk_len,
    input  logic [KW-1:0] coef_f1,
    input  logic [KW-1:0] coef_f2,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_bit,
    output logic          out_last
);

    localparam int AW = (MAX_K > 1) ? $clog2(MAX_K) : 1;

    enc_state_e    state_q;
    logic [KW-1:0] k_q;
    logic [KW-1:0] cnt_q;
    logic [1:0]    ph_q;
    logic [3:0]    tl_q;
    logic          par1_q;
    logic          par2_q;
    logic [2:0]    tz1_q;
    logic [2:0]    tz2_q;

    logic          accept;
    logic          blk_go;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic          cnt_at_end;
    logic          data_active;
    logic          tail_active;
    logic          x_nat;
    logic          x_int;
    logic [KW-1:0] pi_addr;
    logic          step1;
    logic          step2;
    logic          par1;
    logic          par2;
    logic          sys1;
    logic          sys2;
    rsc_reg_t      enc1_st;
    rsc_reg_t      enc2_st;
    logic          tail_bit;
    logic          next_bit;

    // Handshake and phase decode
    always_comb begin
        in_ready    = ((state_q == ST_IDLE) || (state_q == ST_LOAD)) && !out_valid;
        accept      = in_valid && in_ready;
        blk_go      = accept && (state_q == ST_IDLE) && in_start;
        wr_en       = blk_go || (accept && (state_q == ST_LOAD));
        wr_addr     = blk_go ? '0 : cnt_q[AW-1:0];
        cnt_at_end  = (cnt_q == k_q - 1'b1);
        data_active = (state_q == ST_DATA);
        tail_active = (state_q == ST_TAIL);
        step1       = (data_active && ph_q == 2'd0) || (tail_active && tl_q < 4'd3);
        step2       = (data_active && ph_q == 2'd0)
                    || (tail_active && tl_q >= 4'd3 && tl_q < 4'd6);
    end

    pccc_bitbuf #(
        .DEPTH (MAX_K),
        .AW    (AW)
    ) u_buf (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wbit    (in_bit),
        .raddr_a (cnt_q[AW-1:0]),
        .raddr_b (pi_addr[AW-1:0]),
        .rbit_a  (x_nat),
        .rbit_b  (x_int)
    );

    pccc_qpp #(
        .KW (KW)
    ) u_perm (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (blk_go),
        .adv   (data_active && ph_q == 2'd2),
        .k_in  (blk_len),
        .f1_in (coef_f1),
        .f2_in (coef_f2),
        .addr  (pi_addr)
    );

    pccc_rsc u_enc1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (blk_go),
        .step    (step1),
        .term    (tail_active),
        .u       (x_nat),
        .parity  (par1),
        .sys_bit (sys1),
        .st_o    (enc1_st)
    );

    pccc_rsc u_enc2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (blk_go),
        .step    (step2),
        .term    (tail_active),
        .u       (x_int),
        .parity  (par2),
        .sys_bit (sys2),
        .st_o    (enc2_st)
    );

    // Select the tail bit for the current termination slot
    always_comb begin
        case (tl_q)
            4'd0, 4'd1, 4'd2:    tail_bit = sys1;
            4'd3, 4'd4, 4'd5:    tail_bit = sys2;
            4'd6:                tail_bit = tz1_q[0];
            4'd7:                tail_bit = tz1_q[1];
            4'd8:                tail_bit = tz1_q[2];
            4'd9:                tail_bit = tz2_q[0];
            4'd10:               tail_bit = tz2_q[1];
            default:             tail_bit = tz2_q[2];
        endcase
    end

    // Select the next output bit from the data triplet or the tail
    always_comb begin
        if (tail_active) begin
            next_bit = tail_bit;
        end else begin
            case (ph_q)
                2'd0:    next_bit = x_nat;
                2'd1:    next_bit = par1_q;
                default: next_bit = par2_q;
            endcase
        end
    end

    // Sequencer: load the bits, step through the triplets, then the tail
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            cnt_q   <= '0;
            ph_q    <= '0;
            tl_q    <= '0;
            par1_q  <= 1'b0;
            par2_q  <= 1'b0;
            tz1_q   <= '0;
            tz2_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (blk_go) begin
                        k_q   <= blk_len;
                        ph_q  <= '0;
                        if (blk_len == KW'(1)) begin
                            cnt_q   <= '0;
                            state_q <= ST_DATA;
                        end else begin
                            cnt_q   <= KW'(1);
                            state_q <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        if (cnt_at_end) begin
                            cnt_q   <= '0;
                            state_q <= ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    case (ph_q)
                        2'd0: begin
                            par1_q <= par1;
                            par2_q <= par2;
                            ph_q   <= 2'd1;
                        end
                        2'd1: ph_q <= 2'd2;
                        default: begin
                            ph_q <= 2'd0;
                            if (cnt_at_end) begin
                                tl_q    <= '0;
                                state_q <= ST_TAIL;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    endcase
                end
                default: begin
                    if (tl_q < 4'd3) begin
                        tz1_q[tl_q[1:0]] <= par1;
                    end else if (tl_q < 4'd6) begin
                        tz2_q[2'(tl_q - 4'd3)] <= par2;
                    end
                    tl_q <= tl_q + 1'b1;
                    if (tl_q == 4'd11) begin
                        state_q <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Output register: valid, bit and end-of-block flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= data_active || tail_active;
            out_bit   <= (data_active || tail_active) ? next_bit : 1'b0;
            out_last  <= tail_active && (tl_q == 4'd11);
        end
    end

endmodule

// File: rtl/pccc_encoder_chk.sv
// Property checker for pccc_encoder, attached through bind. It counts the
// output bits of each block in order to check the frame length.
module pccc_encoder_chk
    import pccc_pkg::*;
#(
    parameter int KW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_last,
    input logic          data_active,
    input logic [KW-1:0] k_q,
    input logic [KW-1:0] pi_addr,
    input rsc_reg_t      enc1_st,
    input rsc_reg_t      enc2_st
);

    int bits_seen;

    // Count the valid output bits of the current block
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_seen <= 0;
        end else if (out_valid) begin
            bits_seen <= out_last ? 0 : bits_seen + 1;
        end
    end

    p_closed_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (bits_seen + 1 == 3 * int'(k_q) + TAIL_BITS));

    p_gap_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |=> !out_valid);

    p_both_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (enc1_st == '0 && enc2_st == '0));

    p_perm_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_active |-> (pi_addr < k_q));

endmodule

bind pccc_encoder pccc_encoder_chk #(
    .KW (KW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_last    (out_last),
    .data_active (data_active),
    .k_q         (k_q),
    .pi_addr     (pi_addr),
    .enc1_st     (enc1_st),
    .enc2_st     (enc2_st)
);

// File: tb/pccc_encoder_bench.sv
// Self-checking bench: seeded random blocks plus directed corner blocks.
// Each output stream is compared with a reference built by bench functions.
module pccc_encoder_bench;

    localparam int MAX_K = 256;
    localparam int KW    = $clog2(MAX_K + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_start = 1'b0;
    logic          in_bit = 1'b0;
    logic [KW-1:0] blk_len = '0;
    logic [KW-1:0] coef_f1 = '0;
    logic [KW-1:0] coef_f2 = '0;
    logic          in_ready;
    logic          out_valid;
    logic          out_bit;
    logic          out_last;

    int   n_chk = 0;
    int   n_err = 0;
    bit   blk [MAX_K];
    bit   exp_q[$];
    bit   got_q[$];
    int   last_idx;
    bit   got_last;
    bit   collect_on = 1'b0;

    always #2 clk = ~clk;

    pccc_encoder #(
        .MAX_K (MAX_K)
    ) u_pccc_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_bit    (in_bit),
        .blk_len   (blk_len),
        .coef_f1   (coef_f1),
        .coef_f2   (coef_f2),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference constituent step; term=1 forces the feedback to zero
    function automatic bit ref_step(inout bit [2:0] st, input bit u, input bit term,
                                    output bit sys);
        bit a;
        sys = term ? (st[1] ^ st[0]) : u;
        a   = sys ^ st[1] ^ st[0];
        ref_step = a ^ st[2] ^ st[0];
        st  = {a, st[2], st[1]};
    endfunction

    function automatic int perm(input int k, input int f1, input int f2, input int i);
        longint p;
        p = (longint'(f1) * i + longint'(f2) * i * i) % k;
        return int'(p);
    endfunction

    task automatic build_ref(input int k, input int f1, input int f2);
        bit [2:0] s1, s2;
        bit sx, z, zp, xs;
        bit tx1 [3], tx2 [3], tz1 [3], tz2 [3];
        exp_q.delete();
        s1 = '0;
        s2 = '0;
        for (int i = 0; i < k; i++) begin
            z  = ref_step(s1, blk[i], 1'b0, sx);
            zp = ref_step(s2, blk[perm(k, f1, f2, i)], 1'b0, xs);
            exp_q.push_back(blk[i]);
            exp_q.push_back(z);
            exp_q.push_back(zp);
        end
        for (int t = 0; t < 3; t++) tz1[t] = ref_step(s1, 1'b0, 1'b1, tx1[t]);
        for (int t = 0; t < 3; t++) tz2[t] = ref_step(s2, 1'b0, 1'b1, tx2[t]);
        for (int t = 0; t < 3; t++) exp_q.push_back(tx1[t]);
        for (int t = 0; t < 3; t++) exp_q.push_back(tx2[t]);
        for (int t = 0; t < 3; t++) exp_q.push_back(tz1[t]);
        for (int t = 0; t < 3; t++) exp_q.push_back(tz2[t]);
    endtask

    // Capture the output stream just after each rising edge
    always @(posedge clk) begin
        #1;
        if (collect_on && rst_n && out_valid) begin
            got_q.push_back(out_bit);
            if (out_last) begin
                last_idx = got_q.size() - 1;
                got_last = 1'b1;
            end
        end
    end

    task automatic run_block(input int k, input int f1, input int f2, input int mode);
        int n, cyc, bad_d, bad_t, first_d, first_t;
        for (int i = 0; i < k; i++) blk[i] = (mode == 0) ? 1'($urandom % 2) : (mode == 2);
        build_ref(k, f1, f2);
        got_q.delete();
        got_last = 1'b0;
        last_idx = -1;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if ($urandom % 4 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            check(in_ready == 1'b1, "R2", "ready during load", int'(in_ready), 1);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_bit   = blk[i];
            if (i == 0) begin
                blk_len = KW'(k);
                coef_f1 = KW'(f1);
                coef_f2 = KW'(f2);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
        check(in_ready == 1'b0, "R9", "ready after last bit", int'(in_ready), 0);
        cyc = 0;
        forever begin
            @(negedge clk);
            if (got_last) break;
            // Junk while the input is closed; it must have no effect (R9)
            in_valid = 1'($urandom % 2);
            in_start = 1'($urandom % 2);
            in_bit   = 1'($urandom % 2);
            blk_len  = KW'($urandom);
            coef_f1  = KW'($urandom);
            cyc++;
            if (cyc > 20000) begin
                check(1'b0, "R3", "end of block not seen", cyc, 0);
                break;
            end
        end
        in_valid = 1'b0;
        in_start = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R10", "valid after last", int'(out_valid), 0);
        n = 3 * k + 12;
        check(got_q.size() == n, "R3", "stream length", got_q.size(), n);
        check(last_idx == n - 1, "R3", "end flag position", last_idx, n - 1);
        bad_d = 0;
        bad_t = 0;
        first_d = -1;
        first_t = -1;
        for (int i = 0; i < n && i < got_q.size(); i++) begin
            if (got_q[i] != exp_q[i]) begin
                if (i < 3 * k) begin
                    bad_d++;
                    if (first_d < 0) first_d = i;
                end else begin
                    bad_t++;
                    if (first_t < 0) first_t = i;
                end
            end
        end
        check(bad_d == 0, "R4 R5 R6", $sformatf("data bits K=%0d first bad %0d", k, first_d),
              bad_d, 0);
        check(bad_t == 0, "R7 R8", $sformatf("tail bits K=%0d first bad %0d", k, first_t),
              bad_t, 0);
        if (k == 1 || k == MAX_K) begin
            check(got_last && bad_d == 0 && bad_t == 0, "R11",
                  $sformatf("edge size K=%0d", k), bad_d + bad_t, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int k, f1, f2;
        void'($urandom(32'd9127));
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        check(out_last == 1'b0, "R1", "last in reset", int'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
        collect_on = 1'b1;
        run_block(1, 0, 0, 2);          // R11 smallest block
        run_block(2, 1, 1, 0);
        run_block(40, 3, 10, 2);        // all ones, valid permutation
        run_block(40, 3, 10, 1);        // all zeros
        run_block(MAX_K, 15, 32, 0);    // R11 full buffer
        run_block(MAX_K, 255, 254, 2);  // wrap-heavy coefficients
        for (int b = 0; b < 16; b++) begin
            k  = 1 + int'($urandom % MAX_K);
            f1 = int'($urandom % k);
            f2 = int'($urandom % k);
            run_block(k, f1, f2, 0);
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule